// File: doc/BRIEF.md
# Software Write Protection Sequencer

This block sits in front of the page write controller of a byte-wide nonvolatile memory. It watches every captured write cycle, given as an address and a data byte, and decides whether that write may reach the array. It does this by detecting two fixed command keys in the write stream. The short key arms protection and opens one page-load window. The long key turns protection off.

A protection flag records the armed state. Only the power-on reset clears it, which leaves the block open the way a fresh part is delivered. A separate soft reset returns the key detector and the window to idle and leaves the flag alone. When protection is armed, ordinary writes are dropped. The exception is the window opened by the short key: that window stays open until the page controller finishes the programming cycle it starts. After that, protection takes hold again by itself.

Top module: `wprot_seq`

## Requirements
- R1: After power-on reset `prot_on` is 0 and `wr_permit` is 1. Any write that is not a command write is passed through on `store_en` in the same cycle.
- R2: Three writes in a row, with no other write between them, form the arming key: 0xAA to address 0x1555, then 0x55 to 0x0AAA, then 0xA0 to 0x1555. From the cycle after the third write, `prot_on` and `wr_permit` are both 1.
- R3: The arming key sets `prot_on` whether it was 0 or 1 before, and it opens a fresh window each time.
- R4: An open window closes on the first clock edge where `pgm_busy` is low, provided `pgm_busy` was seen high while the window was open. From then on `wr_permit` is 0 while `prot_on` stays 1.
- R5: While `prot_on` is 1 and no window is open, no write asserts `store_en`.
- R6: Six writes in a row form the clearing key: 0xAA@0x1555, 0x55@0x0AAA, 0x80@0x1555, 0xAA@0x1555, 0x55@0x0AAA, 0x20@0x1555. From the cycle after the sixth write, `prot_on` is 0 and the window is closed.
- R7: A command write never asserts `store_en`, whatever the protection state. A command write is one that advances a key, and any 0xAA@0x1555 write is one.
- R8: A write that does not match the next key step returns the detector to idle. If that write is itself 0xAA@0x1555, a new key starts from it. Otherwise the write is stored only when `wr_permit` is 1.
- R9: While `soft_rst` is high, a write is neither stored nor decoded. On that edge the detector and the window go idle and `prot_on` is held.
- R10: `pgm_busy` activity while no window is open changes neither `prot_on` nor `wr_permit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low; also clears protection |
| soft_rst | input | 1 | Synchronous soft reset, active high; keeps protection |
| wr_valid | input | 1 | One captured write cycle this clock |
| wr_addr | input | 13 | Address of the captured write |
| wr_data | input | 8 | Data of the captured write |
| pgm_busy | input | 1 | High while the internal programming cycle runs |
| wr_permit | output | 1 | Writes may currently reach the array |
| store_en | output | 1 | The present write is to be loaded into the page |
| prot_on | output | 1 | Protection flag |

## Verification
The stimulus covers four kinds of key traffic, and each one separates a different fault. Clean arming and clearing keys separate correct key decoding from a wrong step or code. A key broken partway by a stray write, and a key broken by a second 0xAA@0x1555, separate a detector that restarts from one that stalls or misreads the restart. Keys cut by the soft reset show whether protection survives a reset it should survive. Separate `pgm_busy` pulses inside and outside a window show whether protection re-arms only at the end of the window's own programming cycle.

// File: rtl/wprot_seq.sv
module wprot_seq #(
  parameter int AW = 13,
  parameter int DW = 8,
  parameter logic [AW-1:0] KEY_HI = 'h1555,
  parameter logic [AW-1:0] KEY_LO = 'h0AAA,
  parameter logic [DW-1:0] D_FIRST = 'hAA,
  parameter logic [DW-1:0] D_SECOND = 'h55,
  parameter logic [DW-1:0] D_ARM = 'hA0,
  parameter logic [DW-1:0] D_EXTEND = 'h80,
  parameter logic [DW-1:0] D_CLEAR = 'h20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          pgm_busy,
  output logic          wr_permit,
  output logic          store_en,
  output logic          prot_on
);
  localparam int SW = 3;
  localparam logic [SW-1:0] S_FORK = SW'(2);
  localparam logic [SW-1:0] S_LAST = SW'(5);

  logic [SW-1:0] step;
  logic          win, seen_busy, adv;

  wire at_hi  = (wr_addr == KEY_HI);
  wire at_lo  = (wr_addr == KEY_LO);
  wire k_one  = at_hi && (wr_data == D_FIRST);
  wire k_two  = at_lo && (wr_data == D_SECOND);
  wire live   = wr_valid && !soft_rst;

  always_comb begin
    case (step)
      SW'(0), SW'(3): adv = k_one;
      SW'(1), SW'(4): adv = k_two;
      S_FORK:         adv = at_hi && ((wr_data == D_ARM) || (wr_data == D_EXTEND));
      S_LAST:         adv = at_hi && (wr_data == D_CLEAR);
      default:        adv = 1'b0;
    endcase
  end

  wire is_cmd   = adv || k_one;
  wire arm_done = live && adv && (step == S_FORK) && (wr_data == D_ARM);
  wire clr_done = live && adv && (step == S_LAST);

  assign wr_permit = !prot_on || win;
  assign store_en  = live && !is_cmd && wr_permit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step <= '0;
    end else if (soft_rst) begin
      step <= '0;
    end else if (wr_valid) begin
      if (!adv)
        step <= k_one ? SW'(1) : '0;
      else if (arm_done || clr_done)
        step <= '0;
      else
        step <= step + SW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      prot_on <= 1'b0;
    else if (arm_done)
      prot_on <= 1'b1;
    else if (clr_done)
      prot_on <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win       <= 1'b0;
      seen_busy <= 1'b0;
    end else if (soft_rst || clr_done) begin
      win       <= 1'b0;
      seen_busy <= 1'b0;
    end else if (arm_done) begin
      win       <= 1'b1;
      seen_busy <= 1'b0;
    end else if (win) begin
      if (seen_busy && !pgm_busy) begin
        win       <= 1'b0;
        seen_busy <= 1'b0;
      end else if (pgm_busy) begin
        seen_busy <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/wprot_seq_chk.sv
module wprot_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        soft_rst,
  input logic        wr_valid,
  input logic [12:0] wr_addr,
  input logic [7:0]  wr_data,
  input logic        wr_permit,
  input logic        store_en,
  input logic        prot_on,
  input logic [2:0]  step
);
  p_open_when_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !prot_on |-> wr_permit);

  p_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !soft_rst && step == 3'd2 && wr_addr == 13'h1555 && wr_data == 8'hA0)
    |=> (prot_on && wr_permit));

  p_locked_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_on && !wr_permit) |-> !store_en);

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !soft_rst && step == 3'd5 && wr_addr == 13'h1555 && wr_data == 8'h20)
    |=> !prot_on);

  p_cmd_nostore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_addr == 13'h1555 && wr_data == 8'hAA) |-> !store_en);

  p_soft_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (prot_on == $past(prot_on) && step == 3'd0));

  p_store_needs_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    store_en |-> (wr_valid && !soft_rst));
endmodule

bind wprot_seq wprot_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_valid(wr_valid),
  .wr_addr(wr_addr), .wr_data(wr_data), .wr_permit(wr_permit),
  .store_en(store_en), .prot_on(prot_on), .step(step)
);

// File: tb/sim_wprot_seq.sv
`timescale 1ns/1ps
module sim_wprot_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 1'b0, wr_valid = 1'b0, pgm_busy = 1'b0;
  logic [12:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic wr_permit, store_en, prot_on;

  int total = 0;
  int bad = 0;
  bit done = 0;
  string req = "R1";

  int  m_pos = 0;
  bit  m_prot = 0, m_win = 0, m_seen = 0;
  logic [12:0] k_addr [6] = '{13'h1555, 13'h0AAA, 13'h1555, 13'h1555, 13'h0AAA, 13'h1555};
  logic [7:0]  k_data [6] = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, 8'h20};

  always #5 clk = ~clk;

  wprot_seq u0 (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .pgm_busy(pgm_busy),
    .wr_permit(wr_permit), .store_en(store_en), .prot_on(prot_on)
  );

  task automatic check(string r, string what, logic got, logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", r, what, got, exp, $time);
    end
  endtask

  function automatic bit key_match(int p, logic [12:0] a, logic [7:0] d);
    if (p == 2) return (a == 13'h1555) && (d == 8'hA0 || d == 8'h80);
    return (a == k_addr[p]) && (d == k_data[p]);
  endfunction

  task automatic cyc(bit v, logic [12:0] a, logic [7:0] d, bit b, bit s);
    bit adv, first, e_store;
    wr_valid = v; wr_addr = a; wr_data = d; pgm_busy = b; soft_rst = s;
    #1;
    adv   = key_match(m_pos, a, d);
    first = (a == 13'h1555) && (d == 8'hAA);
    e_store = v && !s && !(adv || first) && (!m_prot || m_win);
    check(req, "store_en", store_en, e_store);
    check(req, "wr_permit", wr_permit, !m_prot || m_win);
    check(req, "prot_on", prot_on, m_prot);
    @(posedge clk);
    if (s) begin
      m_pos = 0; m_win = 0; m_seen = 0;
    end else begin
      if (m_win) begin
        if (m_seen && !b) begin m_win = 0; m_seen = 0; end
        else if (b) m_seen = 1;
      end
      if (v) begin
        if (!adv) m_pos = first ? 1 : 0;
        else if (m_pos == 2 && d == 8'hA0) begin
          m_prot = 1; m_win = 1; m_seen = 0; m_pos = 0;
        end else if (m_pos == 5) begin
          m_prot = 0; m_win = 0; m_seen = 0; m_pos = 0;
        end else m_pos++;
      end
    end
    @(negedge clk);
  endtask

  task automatic wr(logic [12:0] a, logic [7:0] d);
    cyc(1, a, d, 0, 0);
  endtask

  task automatic idle(int n, bit b);
    for (int i = 0; i < n; i++) cyc(0, '0, '0, b, 0);
  endtask

  task automatic arm_key();
    wr(13'h1555, 8'hAA); wr(13'h0AAA, 8'h55); wr(13'h1555, 8'hA0);
  endtask

  task automatic close_window();
    idle(1, 0); idle(3, 1); idle(1, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    req = "R1";
    check("R1", "reset prot_on", prot_on, 1'b0);
    check("R1", "reset wr_permit", wr_permit, 1'b1);
    wr(13'h0010, 8'h3C); wr(13'h1555, 8'h12); idle(2, 0);

    req = "R2";
    arm_key();
    check("R2", "armed prot_on", prot_on, 1'b1);
    check("R2", "window permit", wr_permit, 1'b1);
    wr(13'h0040, 8'h01); wr(13'h0041, 8'h02);

    req = "R4";
    close_window();
    check("R4", "closed permit", wr_permit, 1'b0);
    check("R4", "still protected", prot_on, 1'b1);

    req = "R5";
    wr(13'h0042, 8'h77); wr(13'h0AAA, 8'h55);

    req = "R10";
    idle(3, 1); idle(2, 0);
    check("R10", "busy no window", wr_permit, 1'b0);

    req = "R3";
    arm_key();
    check("R3", "rearm permit", wr_permit, 1'b1);
    wr(13'h0100, 8'h5A);
    close_window();

    req = "R8";
    wr(13'h1555, 8'hAA); wr(13'h0AAA, 8'h12);
    wr(13'h1555, 8'hAA); wr(13'h1555, 8'hAA); wr(13'h0AAA, 8'h55); wr(13'h1555, 8'hA0);
    check("R8", "restart arms", wr_permit, 1'b1);
    close_window();

    req = "R9";
    wr(13'h1555, 8'hAA); wr(13'h0AAA, 8'h55);
    cyc(0, '0, '0, 0, 1);
    check("R9", "soft reset keeps prot", prot_on, 1'b1);
    wr(13'h1555, 8'hA0);
    check("R9", "broken by soft reset", wr_permit, 1'b0);
    cyc(1, 13'h0005, 8'h99, 0, 1);

    req = "R7";
    wr(13'h1555, 8'hAA); wr(13'h0AAA, 8'h55); wr(13'h1555, 8'h80);

    req = "R6";
    wr(13'h1555, 8'hAA); wr(13'h0AAA, 8'h55); wr(13'h1555, 8'h20);
    check("R6", "cleared prot", prot_on, 1'b0);
    check("R6", "cleared permit", wr_permit, 1'b1);
    wr(13'h0200, 8'hC3);

    req = "R8";
    wr(13'h1555, 8'hAA); wr(13'h0100, 8'h33); wr(13'h0AAA, 8'h55);

    req = "R7";
    arm_key();
    wr(13'h0300, 8'h44);
    wr(13'h1555, 8'hAA); wr(13'h0AAA, 8'h55); wr(13'h1555, 8'h80);
    wr(13'h1555, 8'hAA); wr(13'h0AAA, 8'h55); wr(13'h1555, 8'h20);
    check("R6", "clear in window", prot_on, 1'b0);
    idle(2, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule